// File: doc/BRIEF.md
# Slot-Reservation Bus Arbiter

This block settles bus ownership on a synchronous shared bus that is divided into fixed time slots. No central grant unit exists. Each attached node drives a single request line of its own, and the lines from all nodes combine on a common wired-OR request bus. A node that wants the bus raises its line during the slot in progress. This books the *next* slot, not the current one. When a slot ends, every node samples the whole request bus at the same moment and decides for itself whether it owns the coming slot. It owns that slot if its own line is set and every line of higher priority is clear.

Line 0 carries the highest priority, and priority drops as the line index rises. With `NUM_LINES` request lines the fabric holds `NUM_LINES + 1` nodes. The extra node sits at the very bottom of the priority order and has no line. It takes the next slot whenever the bus was empty at the boundary, so every slot has an owner. A device keeps its request input high until it gets an acknowledge pulse inside a slot it owns. A node that loses keeps its line up until it wins.

The slot boundary comes in as a one-clock `slotStrobe`. The open-drain wiring is modelled as a logical OR. Data transfer is outside this block.

Top module: `resv_bus_fabric`

## Requirements
- R1: While `rst` is high, every bit of `reqBus` is low whatever `reqIn` holds. After a reset clock, `ownSlot` equals only bit `NUM_LINES` (the line-less node), and it keeps that value until the first boundary.
- R2: Outside a slot it owns, node i (i < `NUM_LINES`) drives `reqBus[i]` equal to its `reqIn[i]`. Each node drives only its own bit, and the line-less node drives no bit.
- R3: Ownership changes only on a clock edge where `slotStrobe` is high. A request raised during a slot does not change the owner of that slot. It takes effect at the next boundary.
- R4: At a boundary where any line is high, bit j of `ownSlot` is set for the following slot, where j is the lowest-numbered line that is high.
- R5: At a boundary where no line is high, node `NUM_LINES` owns the following slot.
- R6: Exactly one bit of `ownSlot` is high at every clock out of reset.
- R7: A node that requests and loses keeps its line high in the slots that follow, as long as its `reqIn` stays high.
- R8: A node's line is low from the start of a slot it won until an `ack` in that slot. If its `reqIn` is still high after that `ack`, the line rises again in the same slot and reserves the next slot.
- R9: An `ack` pulse to a node that does not own the current slot has no effect. Its line keeps following its request, and its pending reservation survives.
- R10: If an owner receives no `ack` before its slot ends, its reservation is released at that boundary. It loses that boundary, and its line returns in the next slot if `reqIn` is still high.
- R11: A node at priority k whose request stays high, while each higher-priority node requests at most once, owns a slot within k+1 boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slotStrobe | input | 1 | One-clock pulse marking the end of a slot |
| reqIn | input | NUM_LINES | Per-node request, held high until acknowledged |
| ack | input | NUM_LINES | Per-node acknowledge pulse, honoured only in an owned slot |
| ownSlot | output | NUM_LINES+1 | One-hot slot owner; the top bit is the line-less node |
| reqBus | output | NUM_LINES | Wired-OR request bus as seen by every node |

## Verification
The assertions assume that `slotStrobe` lasts a single clock. They also assume that a device holds `reqIn` high from the moment it asks until it is acknowledged, and that `ack` goes only to a node that holds a request. The bench drives all inputs on the falling edge. It generates the strobe from one slot task that raises it on the last clock of each slot. Every `ack` is a one-clock pulse issued before the request is lowered, so the request-holding rule is never broken.

// File: rtl/resv_pkg.sv
package resv_pkg;

  // Strobes from a node's decision logic to its state holder.
  typedef struct packed {
    logic boundary;  // slot ends on this clock
    logic grant;     // this node owns the coming slot
    logic ackTake;   // acknowledge accepted in an owned slot
  } slotCtl_t;

endpackage

// File: rtl/resv_node_ctrl.sv
module resv_node_ctrl
  import resv_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int PRIO      = 0
) (
  input  logic                 slotStrobe,
  input  logic [NUM_LINES-1:0] busLines,
  input  logic                 ackIn,
  input  logic                 ownQ,
  output slotCtl_t             ctl
);

  localparam bit HAS_LINE = (PRIO < NUM_LINES);
  localparam logic [NUM_LINES-1:0] LSB_ONE = {{(NUM_LINES-1){1'b0}}, 1'b1};
  // Lines that outrank this node; the line-less node is outranked by all.
  localparam logic [NUM_LINES-1:0] ABOVE_MASK =
    HAS_LINE ? ((LSB_ONE << PRIO) - LSB_ONE) : '1;

  logic winNow;

  generate
    if (HAS_LINE) begin : g_lineNode
      assign winNow = busLines[PRIO] & ~|(busLines & ABOVE_MASK);
    end else begin : g_defaultNode
      assign winNow = ~|(busLines & ABOVE_MASK);
    end
  endgenerate

  always_comb begin
    ctl.boundary = slotStrobe;
    ctl.grant    = slotStrobe & winNow;
    ctl.ackTake  = ackIn & ownQ;
  end

endmodule

// File: rtl/resv_node_dp.sv
module resv_node_dp
  import resv_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int PRIO      = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reqIn,
  input  slotCtl_t             ctl,
  output logic                 ownQ,
  output logic [NUM_LINES-1:0] lineDrive
);

  localparam bit IS_DEFAULT = (PRIO == NUM_LINES);

  // heldQ: the slot was granted and the request is not yet acknowledged.
  logic heldQ;
  logic heldNext;

  always_comb begin
    if (ctl.boundary)     heldNext = ctl.grant;
    else if (ctl.ackTake) heldNext = 1'b0;
    else                  heldNext = heldQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ownQ  <= IS_DEFAULT;
      heldQ <= 1'b0;
    end else begin
      heldQ <= heldNext;
      if (ctl.boundary) ownQ <= ctl.grant;
    end
  end

  generate
    if (!IS_DEFAULT) begin : g_drive
      always_comb begin
        lineDrive       = '0;
        lineDrive[PRIO] = reqIn & ~heldQ & ~rst;
      end
    end else begin : g_noDrive
      logic unusedReq;
      assign unusedReq = reqIn;
      assign lineDrive = '0;
    end
  endgenerate

endmodule

// File: rtl/resv_node.sv
module resv_node
  import resv_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int PRIO      = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 slotStrobe,
  input  logic                 reqIn,
  input  logic                 ackIn,
  input  logic [NUM_LINES-1:0] busLines,
  output logic                 ownSlot,
  output logic [NUM_LINES-1:0] lineDrive
);

  slotCtl_t ctl;
  logic     ownQ;

  resv_node_ctrl #(.NUM_LINES(NUM_LINES), .PRIO(PRIO)) u_ctrl (
    .slotStrobe(slotStrobe),
    .busLines  (busLines),
    .ackIn     (ackIn),
    .ownQ      (ownQ),
    .ctl       (ctl)
  );

  resv_node_dp #(.NUM_LINES(NUM_LINES), .PRIO(PRIO)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .reqIn    (reqIn),
    .ctl      (ctl),
    .ownQ     (ownQ),
    .lineDrive(lineDrive)
  );

  assign ownSlot = ownQ;

endmodule

// File: rtl/resv_bus_fabric.sv
module resv_bus_fabric #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 slotStrobe,
  input  logic [NUM_LINES-1:0] reqIn,
  input  logic [NUM_LINES-1:0] ack,
  output logic [NUM_LINES:0]   ownSlot,
  output logic [NUM_LINES-1:0] reqBus
);

  localparam int NUM_NODES = NUM_LINES + 1;

  logic [NUM_LINES-1:0] nodeDrive [NUM_NODES];

  generate
    for (genvar g = 0; g < NUM_NODES; g++) begin : g_node
      logic nodeReq;
      logic nodeAck;
      if (g < NUM_LINES) begin : g_wired
        assign nodeReq = reqIn[g];
        assign nodeAck = ack[g];
      end else begin : g_tied
        assign nodeReq = 1'b0;
        assign nodeAck = 1'b0;
      end

      resv_node #(.NUM_LINES(NUM_LINES), .PRIO(g)) u_node (
        .clk       (clk),
        .rst       (rst),
        .slotStrobe(slotStrobe),
        .reqIn     (nodeReq),
        .ackIn     (nodeAck),
        .busLines  (reqBus),
        .ownSlot   (ownSlot[g]),
        .lineDrive (nodeDrive[g])
      );
    end
  endgenerate

  // Wired-OR of all node contributions.
  always_comb begin
    reqBus = '0;
    for (int n = 0; n < NUM_NODES; n++) reqBus = reqBus | nodeDrive[n];
  end

endmodule

// File: rtl/resv_bus_fabric_chk.sv
module resv_bus_fabric_chk #(
  parameter int NUM_LINES = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 slotStrobe,
  input logic [NUM_LINES-1:0] reqIn,
  input logic [NUM_LINES-1:0] ack,
  input logic [NUM_LINES:0]   ownSlot,
  input logic [NUM_LINES-1:0] reqBus
);

  localparam logic [NUM_LINES:0] DEFAULT_ONLY = {1'b1, {NUM_LINES{1'b0}}};

  // Expected next owner: lowest set line isolated, or the line-less node.
  logic [NUM_LINES:0] expectVec;
  assign expectVec = {reqBus == '0, reqBus & (~reqBus + 1'b1)};

  logic unusedAck;
  assign unusedAck = ^ack;

  assert_reset_lines_R1: assert property (@(posedge clk) rst |-> reqBus == '0);
  assert_reset_owner_R1: assert property (@(posedge clk) rst |=> ownSlot == DEFAULT_ONLY);

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (rst)
    !slotStrobe |=> $stable(ownSlot));

  assert_winner_R4: assert property (@(posedge clk) disable iff (rst)
    slotStrobe |=> ownSlot == $past(expectVec));

  assert_idle_default_R5: assert property (@(posedge clk) disable iff (rst)
    slotStrobe && reqBus == '0 |=> ownSlot[NUM_LINES]);

  assert_one_owner_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(ownSlot) == 1);

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assert_line_tracks_R2: assert property (@(posedge clk) disable iff (rst)
        !ownSlot[i] |-> reqBus[i] == reqIn[i]);
      assert_loser_holds_R7: assert property (@(posedge clk) disable iff (rst)
        slotStrobe && reqBus[i] && !expectVec[i] |=> !reqIn[i] || reqBus[i]);
      assert_won_line_low_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ownSlot[i]) |-> !reqBus[i]);
    end
  endgenerate

endmodule

bind resv_bus_fabric resv_bus_fabric_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .slotStrobe(slotStrobe),
  .reqIn     (reqIn),
  .ack       (ack),
  .ownSlot   (ownSlot),
  .reqBus    (reqBus)
);

// File: tb/resv_bus_fabric_bench.sv
`timescale 1ns/1ps
module resv_bus_fabric_bench;

  localparam int NL       = 16;
  localparam int SLOT_LEN = 4;
  localparam int NVEC     = 10;

  localparam logic [NL-1:0] VEC_REQ [NVEC] = '{
    16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'hA0A0,
    16'h0100, 16'h8001, 16'h0006, 16'h4000, 16'hF000};
  localparam int VEC_OWN [NVEC] = '{16, 0, 15, 0, 5, 8, 0, 1, 14, 12};

  logic          clk = 1'b0;
  logic          rst;
  logic          slotStrobe;
  logic [NL-1:0] reqIn;
  logic [NL-1:0] ack;
  logic [NL:0]   ownSlot;
  logic [NL-1:0] reqBus;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  resv_bus_fabric #(.NUM_LINES(NL)) u_resv_bus_fabric (
    .clk(clk), .rst(rst), .slotStrobe(slotStrobe),
    .reqIn(reqIn), .ack(ack), .ownSlot(ownSlot), .reqBus(reqBus));

  function automatic logic [NL:0] expOwn(input int idx);
    return (NL+1)'(1) << idx;
  endfunction

  function automatic int ownerIdx(input logic [NL:0] o);
    int r = -1;
    for (int b = 0; b <= NL; b++) if (o[b] && r < 0) r = b;
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runSlot();
    for (int c = 0; c < SLOT_LEN; c++) begin
      slotStrobe = (c == SLOT_LEN - 1);
      @(negedge clk);
    end
    slotStrobe = 1'b0;
  endtask

  task automatic ackOwner(input int o);
    if (o < NL) begin
      ack[o] = 1'b1;
      @(negedge clk);
      ack = '0;
      reqIn[o] = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int served;
    bit done;
    rst = 1'b1; slotStrobe = 1'b0; ack = '0; reqIn = '1;
    repeat (3) @(negedge clk);
    check("R1 bus low in reset", 32'(reqBus), 32'h0);
    check("R1 default owns", 32'(ownSlot), 32'(expOwn(NL)));
    reqIn = '0; rst = 1'b0;
    @(negedge clk);
    check("R1 default owns after release", 32'(ownSlot), 32'(expOwn(NL)));

    // Table walk: one request pattern per slot, idle slot between.
    for (int v = 0; v < NVEC; v++) begin
      reqIn = VEC_REQ[v];
      runSlot();
      check("R4 R5 table owner", 32'(ownSlot), 32'(expOwn(VEC_OWN[v])));
      check("R6 single owner", 32'($countones(ownSlot)), 32'd1);
      ackOwner(VEC_OWN[v]);
      reqIn = '0;
      runSlot();
      check("R5 idle slot default", 32'(ownSlot), 32'(expOwn(NL)));
    end

    // R3: a request mid-slot books the next slot only.
    reqIn = 16'h0001;
    @(negedge clk);
    check("R2 line follows request", 32'(reqBus), 32'h1);
    check("R3 current slot unchanged", 32'(ownSlot), 32'(expOwn(NL)));
    runSlot();
    check("R3 next slot taken", 32'(ownSlot), 32'(expOwn(0)));
    ackOwner(0); runSlot();

    // R7 / R8: loser keeps line, winner line drops.
    reqIn = 16'h0088;
    runSlot();
    check("R4 node3 wins", 32'(ownSlot), 32'(expOwn(3)));
    check("R7 loser line held", 32'(reqBus[7]), 32'd1);
    check("R8 winner line low", 32'(reqBus[3]), 32'd0);
    ackOwner(3);
    runSlot();
    check("R7 loser served next", 32'(ownSlot), 32'(expOwn(7)));
    ackOwner(7); runSlot();

    // R9: ack to a non-owner is ignored.
    reqIn = 16'h0024;
    runSlot();
    check("R4 node2 wins", 32'(ownSlot), 32'(expOwn(2)));
    ack[5] = 1'b1;
    @(negedge clk);
    ack = '0;
    check("R9 stray ack keeps line", 32'(reqBus[5]), 32'd1);
    check("R9 owner unchanged", 32'(ownSlot), 32'(expOwn(2)));
    ackOwner(2);
    runSlot();
    check("R9 reservation survived", 32'(ownSlot), 32'(expOwn(5)));
    ackOwner(5); runSlot();

    // R8: back-to-back slots after ack with request still high.
    reqIn = 16'h0200;
    runSlot();
    check("R8 node9 wins", 32'(ownSlot), 32'(expOwn(9)));
    check("R8 line low before ack", 32'(reqBus[9]), 32'd0);
    ack[9] = 1'b1;
    @(negedge clk);
    ack = '0;
    check("R8 line back after ack", 32'(reqBus[9]), 32'd1);
    runSlot();
    check("R8 second slot", 32'(ownSlot), 32'(expOwn(9)));
    ackOwner(9); runSlot();

    // R10: owner never acknowledged.
    reqIn = 16'h0800;
    runSlot();
    check("R10 node11 wins", 32'(ownSlot), 32'(expOwn(11)));
    runSlot();
    check("R10 released to default", 32'(ownSlot), 32'(expOwn(NL)));
    check("R10 line returns", 32'(reqBus[11]), 32'd1);
    runSlot();
    check("R10 node11 again", 32'(ownSlot), 32'(expOwn(11)));
    ackOwner(11); runSlot();

    // R11: priority 4 with four one-shot higher requesters.
    reqIn = 16'h001F;
    served = 0; done = 1'b0;
    for (int s = 1; s <= 8; s++) begin
      if (!done) begin
        runSlot();
        if (ownSlot[4]) begin
          done = 1'b1;
          served = s;
        end else begin
          ackOwner(ownerIdx(ownSlot));
        end
      end
    end
    check("R11 served within k+1", 32'(served), 32'd5);
    ackOwner(4); runSlot();
    check("R6 single owner end", 32'($countones(ownSlot)), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule